// File: doc/BRIEF.md
# Channel Crossbar Source Selector

This block sits on the write side of a queue and rearranges each incoming 40-bit word before it is stored. It treats the word as eight 5-bit lanes. Every output lane picks its value from one of the eight input lanes, and a small routing table decides which one. The same table can express a plain pass-through, one source copied to every lane, several outputs sharing a source while others keep their own, or pairs of adjacent lanes moved together so that the word behaves as four 10-bit channels.

The routing table has its own load strobe and can be rewritten between any two words. Traffic does not have to stop for a reload. Each word is switched with the table as it stands at the clock edge that captures the word, and the result is registered. A valid flag comes out one cycle after the write strobe and marks the switched word for the storage that follows.

Top module: `cx_chan_switch`

## Requirements
- R1: Output lane i occupies `dout[5i+4:5i]` and carries input lane s, `din[5s+4:5s]`, where s is the source index held for output i.
- R2: The source index for output i is a 3-bit field at bits `[3i+2:3i]` of the routing table. The value s selects input lane s.
- R3: When `cfg_we` is high at a rising edge, `din[23:0]` is copied into the routing table. Words captured on later edges use the new table.
- R4: While `cfg_we` is low, the routing table keeps its value whatever `din` and `wr_en` do.
- R5: A word captured on the same edge as a table load is switched with the table that was in force before the load.
- R6: `dout_vld` is high in exactly the cycle after a cycle in which `wr_en` was high, and `dout` then holds that word, switched.
- R7: While no word is captured, `dout` keeps the last switched word.
- R8: After the active-low reset the table is the identity (output i takes input i), `dout` is zero and `dout_vld` is low.
- R9: Any table value is legal. Repeated source indices give multicast, and a single repeated index gives broadcast.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; restores the identity table |
| wr_en | input | 1 | Capture `din` as a word to switch |
| cfg_we | input | 1 | Load the routing table from `din[23:0]` |
| din | input | 40 | Data word, and the table value during a load |
| dout | output | 40 | Registered switched word |
| dout_vld | output | 1 | Marks a new switched word on `dout` |

## Verification
Words are sent through an identity map, a broadcast of one lane, a multicast map that mixes shared and private sources, a paired-lane map acting as four 10-bit channels, and a full reversal. Each of these exposes a different way a lane multiplexer can be miswired. A table load in the same cycle as a write separates the old-map rule from a design that forwards the new table early. A run of loads changing every cycle shows whether each word picks up the table from the previous edge. Idle stretches with random data on `din` and both strobes low show whether the table and the output register hold their values.

// File: rtl/cx_pkg.sv
`timescale 1ns/1ps
package cx_pkg;
    localparam int unsigned CX_LANES  = 8;
    localparam int unsigned CX_LANE_W = 5;
    localparam int unsigned CX_SEL_W  = $clog2(CX_LANES);
endpackage

// File: rtl/cx_map_reg.sv
`timescale 1ns/1ps
module cx_map_reg
    import cx_pkg::*;
#(
    parameter int unsigned LANES = CX_LANES,
    parameter int unsigned SEL_W = CX_SEL_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   load,
    input  logic [LANES*SEL_W-1:0] load_val,
    output logic [LANES*SEL_W-1:0] map
);
    localparam int unsigned MAP_W = LANES * SEL_W;

    typedef struct packed {
        logic [MAP_W-1:0] map;
    } map_st_t;

    map_st_t          s_d, s_q;
    logic [MAP_W-1:0] ident;

    // Reset table: output lane g sources input lane g.
    for (genvar g = 0; g < LANES; g++) begin : g_ident
        assign ident[g*SEL_W +: SEL_W] = SEL_W'(g);
    end

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.map = load_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.map <= ident;
        end else begin
            s_q <= s_d;
        end
    end

    assign map = s_q.map;

    // R4: table untouched without a load strobe
    p_map_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(map));

    // R3: a load lands in the table on the next cycle
    p_map_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (map == $past(load_val)));
endmodule

// File: rtl/cx_lane_mux.sv
`timescale 1ns/1ps
module cx_lane_mux
    import cx_pkg::*;
#(
    parameter int unsigned LANES  = CX_LANES,
    parameter int unsigned LANE_W = CX_LANE_W,
    parameter int unsigned SEL_W  = CX_SEL_W
) (
    input  logic [LANES*LANE_W-1:0] word_in,
    input  logic [LANES*SEL_W-1:0]  map,
    output logic [LANES*LANE_W-1:0] word_out
);
    logic [LANE_W-1:0] lane_in [LANES];

    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_in[g] = word_in[g*LANE_W +: LANE_W];
    end

    // One independent selector per output lane (R1, R2, R9).
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [SEL_W-1:0] sel;
        assign sel = map[g*SEL_W +: SEL_W];
        assign word_out[g*LANE_W +: LANE_W] = lane_in[sel];
    end
endmodule

// File: rtl/cx_out_stage.sv
`timescale 1ns/1ps
module cx_out_stage #(
    parameter int unsigned WORD_W = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] word_in,
    output logic [WORD_W-1:0] dout,
    output logic              dout_vld
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
    } out_st_t;

    out_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = wr_en;
        if (wr_en) begin
            s_d.word = word_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout     = s_q.word;
    assign dout_vld = s_q.vld;

    // R6: valid follows the write strobe by one cycle
    p_vld_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> dout_vld);

    // R6: no valid without a write in the previous cycle
    p_no_spurious_vld_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !dout_vld);

    // R7: output word held while nothing is captured
    p_dout_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(dout));
endmodule

// File: rtl/cx_chan_switch.sv
`timescale 1ns/1ps
module cx_chan_switch
    import cx_pkg::*;
#(
    parameter int unsigned LANES  = CX_LANES,
    parameter int unsigned LANE_W = CX_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    cfg_we,
    input  logic [LANES*LANE_W-1:0] din,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_vld
);
    localparam int unsigned SEL_W  = $clog2(LANES);
    localparam int unsigned WORD_W = LANES * LANE_W;
    localparam int unsigned MAP_W  = LANES * SEL_W;

    logic [MAP_W-1:0]  map;
    logic [WORD_W-1:0] switched;

    cx_map_reg #(.LANES(LANES), .SEL_W(SEL_W)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cfg_we),
        .load_val (din[MAP_W-1:0]),
        .map      (map)
    );

    // The mux sees the registered table, so a same-edge load cannot affect this word (R5).
    cx_lane_mux #(.LANES(LANES), .LANE_W(LANE_W), .SEL_W(SEL_W)) u_mux (
        .word_in  (din),
        .map      (map),
        .word_out (switched)
    );

    cx_out_stage #(.WORD_W(WORD_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .word_in  (switched),
        .dout     (dout),
        .dout_vld (dout_vld)
    );
endmodule

// File: tb/cx_chan_switch_tb_top.sv
`timescale 1ns/1ps
module cx_chan_switch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        cfg_we = 1'b0;
    logic [39:0] din = '0;
    logic [39:0] dout;
    logic        dout_vld;

    always #4 clk = ~clk;

    cx_chan_switch dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .cfg_we(cfg_we),
        .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    typedef struct {
        logic [39:0] data;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    logic [23:0] model_map;
    logic [39:0] last_exp;
    bit          have_last = 0;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 0;

    // Source index s for output i (R2): field [3i+2:3i]; lane i = bits [5i+4:5i] (R1)
    function automatic logic [39:0] swz(input logic [39:0] w, input logic [23:0] m);
        logic [39:0] r;
        for (int i = 0; i < 8; i++) begin
            int s;
            s = int'(m[3*i +: 3]);
            r[5*i +: 5] = w[5*s +: 5];
        end
        return r;
    endfunction

    function automatic logic [23:0] mk(input int s7, s6, s5, s4, s3, s2, s1, s0);
        return {3'(s7), 3'(s6), 3'(s5), 3'(s4), 3'(s3), 3'(s2), 3'(s1), 3'(s0)};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; pushes the expected switched word.
    task automatic step(input logic wr, input logic cw, input logic [39:0] d, input string tag);
        exp_t e;
        @(posedge clk);
        #2;
        wr_en  = wr;
        cfg_we = cw;
        din    = d;
        if (wr) begin
            e.data = swz(d, model_map);   // old table applies (R5)
            e.tag  = tag;
            sb_q.push_back(e);
        end
        if (cw) model_map = d[23:0];
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            logic [39:0] junk;
            junk = {$urandom, $urandom};
            step(1'b0, 1'b0, junk, "");
        end
    endtask

    // Monitor: checks at the falling edge, away from the driving edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (dout_vld) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R6 unexpected valid", dout, '0);
                end else begin
                    exp_t e;
                    e = sb_q.pop_front();
                    check(dout === e.data, e.tag, dout, e.data);
                    last_exp  = e.data;
                    have_last = 1;
                end
            end else if (have_last) begin
                check(dout === last_exp, "R7 hold", dout, last_exp);
            end
        end
    end

    initial begin
        model_map = mk(7, 6, 5, 4, 3, 2, 1, 0);
        repeat (2) @(negedge clk);
        check(dout === '0, "R8 reset dout", dout, '0);
        check(dout_vld === 1'b0, "R8 reset valid", {39'd0, dout_vld}, '0);
        @(posedge clk);
        #2 rst_n = 1'b1;

        // identity after reset
        step(1, 0, 40'h12_3456_789A, "R8 identity");
        step(1, 0, 40'hFE_DCBA_9876, "R1 identity");
        idle(3);

        // broadcast lane 2
        step(0, 1, {16'hA5A5, mk(2, 2, 2, 2, 2, 2, 2, 2)}, "");
        step(1, 0, 40'h01_2345_6789, "R9 broadcast");
        step(1, 0, 40'hAB_CDEF_0123, "R3 broadcast");

        // load multicast map together with a write: the write uses broadcast (R5)
        step(1, 1, {16'h5A5A, mk(7, 6, 7, 6, 3, 2, 3, 3)}, "R5 same-cycle load");
        step(1, 0, 40'h13_579B_DF02, "R9 multicast");
        step(1, 0, 40'h24_68AC_E135, "R9 multicast");

        // paired lanes: four 10-bit channels
        step(0, 1, {16'h0000, mk(1, 0, 5, 4, 7, 6, 3, 2)}, "");
        step(1, 0, 40'h8C_4E2F_1A3B, "R1 pair switch");
        step(1, 0, 40'h77_3311_CC55, "R1 pair switch");

        // idle with junk data: table must survive (R4)
        idle(4);
        step(1, 0, 40'h9E_37C1_5D0B, "R4 table kept");

        // a different table each cycle, with writes in every cycle
        step(1, 1, {16'h1111, mk(0, 1, 2, 3, 4, 5, 6, 7)}, "R5 chain");
        step(1, 1, {16'h2222, mk(3, 3, 3, 3, 3, 3, 3, 3)}, "R3 reverse");
        step(1, 1, {16'h3333, mk(6, 7, 4, 5, 2, 3, 0, 1)}, "R3 broadcast 3");
        step(1, 0, 40'hC3_A50F_F0E1, "R3 swap pairs");
        step(0, 0, 40'h0, "");
        idle(3);

        n_checks++;
        if (sb_q.size() != 0) begin
            n_fail++;
            $display("FAIL R6 missing outputs actual=%0d expected=0", sb_q.size());
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule